// File: doc/BRIEF.md
# Coprocessor Bus Glue Logic

This block sits between a host processor bus and a network coprocessor that can master the same bus. It watches host bus cycles and turns writes into three address windows into coprocessor controls. A registered channel-attention strobe tells the coprocessor to look at its command area. A registered coprocessor reset is driven by a decoded write or by system reset. An active-low, purely combinational port-access strobe marks accesses to the coprocessor's port window.

While the coprocessor holds the bus, meaning HOLD and HLDA are both high, the block drives the memory/IO and data/control cycle-type lines high. At all other times it releases them so the host can drive them. When the host caches the shared memory, the block watches the start of each coprocessor write cycle. For a write into the cacheable range it sends the host a one-clock active-low invalidation strobe.

Each window is a base address and a mask, both set by parameters. An address hits a window when `(addr & MASK) == (BASE & MASK)`. Reset is synchronous and active high.

Top module: `cop_bus_glue`

## Requirements
- R1: `chan_attn` is registered: it is high in the cycle after a clock edge at which the address hits the channel-attention window, `ads_n` is 0 and `d0` is 1. It is low after any edge where one of these conditions is false.
- R2: `chan_attn` returns low on the clock after its decode condition stops holding, for example when `ads_n` returns to 1 or `d0` is 0.
- R3: `cop_reset` is registered. It is high after a clock edge at which the address hits the reset window and `d0` is 1, whatever the value of `ads_n`. With `rst` low it goes low on the clock after that condition ends.
- R4: `cop_reset` is high after every clock edge at which `rst` is 1, and stays high for as long as `rst` stays high.
- R5: `port_n` is combinational. It is 0 exactly while the address hits the port window and `ads_n` is 0, and 1 otherwise.
- R6: While `hold` and `hlda` are both 1, the block drives `mio` and `dc` to 1.
- R7: While `hold` and `hlda` are not both 1, the block leaves `mio` and `dc` at high impedance, so a value driven by the host is seen on them unchanged.
- R8: `snoop_n` pulses to 0 for one cycle after a clock edge at which all of these hold:
  - `ads_n` has just fallen from 1 to 0;
  - `wr_rdn` is 1 (a write);
  - `hold`, `hlda` and `cache_en` are all 1;
  - the address falls in the cacheable window.
- R9: `snoop_n` stays 1 for coprocessor reads (`wr_rdn` = 0), while `hlda` is 0, and for addresses outside the cacheable window.
- R10: While `cache_en` is 0, `snoop_n` stays 1 whatever the bus activity.
- R11: `snoop_n` is low for only one clock per bus cycle, even when `ads_n` is held low over several clocks.
- R12: After reset, `chan_attn` is 0, `snoop_n` is 1 and `cop_reset` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | System reset, synchronous, active high |
| addr | input | AW | Bus address |
| ads_n | input | 1 | Address strobe, active low |
| wr_rdn | input | 1 | Cycle direction, 1 = write, 0 = read |
| d0 | input | 1 | Data bit 0 |
| hold | input | 1 | Bus request from coprocessor |
| hlda | input | 1 | Bus grant from host |
| cache_en | input | 1 | Enables invalidation strobes for cached shared memory |
| chan_attn | output | 1 | Channel-attention strobe to the coprocessor, registered |
| cop_reset | output | 1 | Reset to the coprocessor, registered |
| port_n | output | 1 | Port-access strobe, active low, combinational |
| snoop_n | output | 1 | Cache-invalidation strobe to the host, active low |
| mio | inout | 1 | Memory/IO cycle indicator, driven high during hold acknowledge |
| dc | inout | 1 | Data/control cycle indicator, driven high during hold acknowledge |

## Verification
Each decode window is tried with a matching address and also with a neighbouring address that misses. This separates a real decode from a strobe that fires on any cycle. The reset decode is applied with the strobe inactive, and again with `d0` cleared, to show that it ignores the strobe but depends on the data bit.

The invalidation path is driven with four patterns:
- a write into the cacheable range, which must produce a pulse;
- a read into that range;
- a write outside the range;
- writes with HLDA low or caching disabled.

The last three must stay silent. A strobe held low over three clocks shows the difference between edge detection and level detection. Hold-acknowledge cycles alternate with cycles in which the host drives the cycle-type lines to 0, which shows both the forcing and the release.

// File: rtl/cop_glue_pkg.sv
package cop_glue_pkg;

    localparam int unsigned GLUE_AW = 32;

    // Index of each decode window in the decoder's hit vector
    typedef enum logic [1:0] {
        WIN_ATTN  = 2'd0,
        WIN_RESET = 2'd1,
        WIN_PORT  = 2'd2,
        WIN_CACHE = 2'd3
    } win_idx_e;

    localparam int unsigned NUM_WIN = 4;

    // Sampled bus cycle passed to the registered units
    typedef struct packed {
        logic strobe;   // address strobe active (active high inside)
        logic write;
        logic data0;
        logic held;     // coprocessor owns the bus
    } bus_cyc_t;

    // Registered control outputs
    typedef struct packed {
        logic attn;
        logic cop_rst;
    } ctl_t;

    function automatic bus_cyc_t make_cyc(input logic ads_n, input logic wr_rdn,
                                          input logic d0, input logic hold,
                                          input logic hlda);
        bus_cyc_t c;
        c.strobe = ~ads_n;
        c.write  = wr_rdn;
        c.data0  = d0;
        c.held   = hold & hlda;
        return c;
    endfunction

endpackage

// File: rtl/glue_win_dec.sv
module glue_win_dec
    import cop_glue_pkg::*;
#(
    parameter int unsigned AW = GLUE_AW,
    parameter logic [NUM_WIN-1:0][AW-1:0] BASES = '0,
    parameter logic [NUM_WIN-1:0][AW-1:0] MASKS = '0
) (
    input  logic [AW-1:0]      addr,
    output logic [NUM_WIN-1:0] hit
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [AW-1:0] M = MASKS[w];
        localparam logic [AW-1:0] B = BASES[w] & MASKS[w];
        assign hit[w] = ((addr & M) == B);
    end

endmodule

// File: rtl/glue_ctl_regs.sv
module glue_ctl_regs
    import cop_glue_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_cyc_t cyc,
    input  logic     hit_attn,
    input  logic     hit_reset,
    output ctl_t     ctl
);

    ctl_t ctl_d;

    always_comb begin
        ctl_d.attn    = hit_attn & cyc.strobe & cyc.data0;
        ctl_d.cop_rst = (hit_reset & cyc.data0) | rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.attn    <= 1'b0;
            ctl.cop_rst <= 1'b1;
        end else begin
            ctl <= ctl_d;
        end
    end

    // R1
    attn_src_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.attn |-> ($past(cyc.strobe) && $past(cyc.data0)));

    // R4
    rst_hold_chk: assert property (@(posedge clk)
        rst |=> ctl.cop_rst);

endmodule

// File: rtl/glue_snoop.sv
module glue_snoop
    import cop_glue_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_cyc_t cyc,
    input  logic     hit_cache,
    input  logic     cache_en,
    output logic     snoop_n
);

    logic strobe_q;   // strobe state at previous edge
    logic start;

    // Only the first clock of a strobe counts as a cycle start
    assign start = cyc.strobe & ~strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            snoop_n  <= 1'b1;
        end else begin
            strobe_q <= cyc.strobe;
            snoop_n  <= ~(start & cyc.write & cyc.held & cache_en & hit_cache);
        end
    end

    // R11
    snoop_single_chk: assert property (@(posedge clk) disable iff (rst)
        !snoop_n |=> snoop_n);

    // R9
    snoop_write_chk: assert property (@(posedge clk) disable iff (rst)
        !snoop_n |-> ($past(cyc.write) && $past(cyc.held)));

    // R10
    snoop_en_chk: assert property (@(posedge clk) disable iff (rst)
        !snoop_n |-> $past(cache_en));

endmodule

// File: rtl/cop_bus_glue.sv
module cop_bus_glue
    import cop_glue_pkg::*;
#(
    parameter int unsigned   AW         = GLUE_AW,
    parameter logic [AW-1:0] ATTN_BASE  = 32'h0000_0300,
    parameter logic [AW-1:0] ATTN_MASK  = 32'hFFFF_FFFC,
    parameter logic [AW-1:0] RST_BASE   = 32'h0000_0304,
    parameter logic [AW-1:0] RST_MASK   = 32'hFFFF_FFFC,
    parameter logic [AW-1:0] PORT_BASE  = 32'h0000_0308,
    parameter logic [AW-1:0] PORT_MASK  = 32'hFFFF_FFFC,
    parameter logic [AW-1:0] CACHE_BASE = 32'h0010_0000,
    parameter logic [AW-1:0] CACHE_MASK = 32'hFFF0_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          ads_n,
    input  logic          wr_rdn,
    input  logic          d0,
    input  logic          hold,
    input  logic          hlda,
    input  logic          cache_en,
    output logic          chan_attn,
    output logic          cop_reset,
    output logic          port_n,
    output logic          snoop_n,
    inout  wire           mio,
    inout  wire           dc
);

    localparam logic [NUM_WIN-1:0][AW-1:0] BASES = {CACHE_BASE, PORT_BASE, RST_BASE, ATTN_BASE};
    localparam logic [NUM_WIN-1:0][AW-1:0] MASKS = {CACHE_MASK, PORT_MASK, RST_MASK, ATTN_MASK};

    logic [NUM_WIN-1:0] hit;
    bus_cyc_t           cyc;
    ctl_t               ctl;

    assign cyc = make_cyc(ads_n, wr_rdn, d0, hold, hlda);

    glue_win_dec #(
        .AW    (AW),
        .BASES (BASES),
        .MASKS (MASKS)
    ) u_dec (
        .addr (addr),
        .hit  (hit)
    );

    glue_ctl_regs u_ctl (
        .clk       (clk),
        .rst       (rst),
        .cyc       (cyc),
        .hit_attn  (hit[WIN_ATTN]),
        .hit_reset (hit[WIN_RESET]),
        .ctl       (ctl)
    );

    glue_snoop u_snoop (
        .clk       (clk),
        .rst       (rst),
        .cyc       (cyc),
        .hit_cache (hit[WIN_CACHE]),
        .cache_en  (cache_en),
        .snoop_n   (snoop_n)
    );

    assign chan_attn = ctl.attn;
    assign cop_reset = ctl.cop_rst;
    assign port_n    = ~(hit[WIN_PORT] & cyc.strobe);

    // Cycle-type lines: forced high under hold acknowledge, released otherwise
    assign mio = cyc.held ? 1'b1 : 1'bz;
    assign dc  = cyc.held ? 1'b1 : 1'bz;

    // R5
    port_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !port_n |-> !ads_n);

    // R6
    held_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && hlda) |-> (mio && dc));

endmodule

// File: tb/cop_bus_glue_tb.sv
module cop_bus_glue_tb_top;

    localparam logic [31:0] A_ATTN  = 32'h0000_0300;
    localparam logic [31:0] A_RST   = 32'h0000_0304;
    localparam logic [31:0] A_PORT  = 32'h0000_0308;
    localparam logic [31:0] A_CACHE = 32'h0010_0040;
    localparam logic [31:0] A_OTHER = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst, ads_n, wr_rdn, d0, hold, hlda, cache_en;
    logic [31:0] addr;
    logic        chan_attn, cop_reset, port_n, snoop_n;
    logic        host_en, host_val;
    wire         mio, dc;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  attn;
        logic  crst;
        logic  snp;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    logic prev_ads_n = 1'b1;

    always #10 clk = ~clk;

    assign mio = host_en ? host_val : 1'bz;
    assign dc  = host_en ? host_val : 1'bz;

    cop_bus_glue dut_i (
        .clk(clk), .rst(rst), .addr(addr), .ads_n(ads_n), .wr_rdn(wr_rdn),
        .d0(d0), .hold(hold), .hlda(hlda), .cache_en(cache_en),
        .chan_attn(chan_attn), .cop_reset(cop_reset), .port_n(port_n),
        .snoop_n(snoop_n), .mio(mio), .dc(dc)
    );

    function automatic logic in_win(logic [31:0] a, logic [31:0] b, logic [31:0] m);
        return (a & m) == (b & m);
    endfunction

    task automatic check(string req, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, expv);
        end
    endtask

    // Monitor: compare registered outputs after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " chan_attn"}, chan_attn, e.attn);
            check({e.tag, " cop_reset"}, cop_reset, e.crst);
            check({e.tag, " snoop_n"},   snoop_n,   e.snp);
        end
    end

    // Driver: one bus clock, expected registered results pushed to the queue
    task automatic cyc(string tag, logic r, logic [31:0] a, logic as_n, logic wr,
                       logic dbit, logic h, logic ha, logic ce, logic hen, logic hv);
        exp_t e;
        @(negedge clk);
        rst = r; addr = a; ads_n = as_n; wr_rdn = wr; d0 = dbit;
        hold = h; hlda = ha; cache_en = ce; host_en = hen; host_val = hv;
        e.tag  = tag;
        e.attn = !r && in_win(a, A_ATTN, 32'hFFFF_FFFC) && !as_n && dbit;
        e.crst = r || (in_win(a, A_RST, 32'hFFFF_FFFC) && dbit);
        e.snp  = r || !(!as_n && prev_ads_n && wr && h && ha && ce &&
                        in_win(a, 32'h0010_0000, 32'hFFF0_0000));
        prev_ads_n = r ? 1'b1 : as_n;
        exp_q.push_back(e);
        #1;
        if (!r) begin
            // R5 combinational port strobe
            check({tag, " R5 port_n"}, port_n,
                  !(in_win(a, A_PORT, 32'hFFFF_FFFC) && !as_n));
            if (h && ha) begin
                check({tag, " R6 mio"}, mio, 1'b1);
                check({tag, " R6 dc"},  dc,  1'b1);
            end else if (hen) begin
                check({tag, " R7 mio"}, mio, hv);
                check({tag, " R7 dc"},  dc,  hv);
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; addr = 0; ads_n = 1; wr_rdn = 0; d0 = 0;
        hold = 0; hlda = 0; cache_en = 0; host_en = 1; host_val = 0;
        // R12 / R4 reset state
        cyc("R12 reset", 1, A_ATTN, 0, 1, 1, 0, 0, 0, 1, 0);
        cyc("R4 reset held", 1, A_OTHER, 1, 0, 0, 0, 0, 0, 1, 0);
        cyc("R3 idle", 0, A_OTHER, 1, 0, 0, 0, 0, 0, 1, 0);
        // R1 channel attention
        cyc("R1 attn hit", 0, A_ATTN, 0, 1, 1, 0, 0, 0, 1, 1);
        cyc("R2 attn strobe off", 0, A_ATTN, 1, 1, 1, 0, 0, 0, 1, 0);
        cyc("R2 attn d0 low", 0, A_ATTN, 0, 1, 0, 0, 0, 0, 1, 0);
        cyc("R1 attn miss addr", 0, A_PORT, 0, 1, 1, 0, 0, 0, 1, 0);
        // R3 coprocessor reset decode ignores strobe
        cyc("R3 reset decode", 0, A_RST, 1, 1, 1, 0, 0, 0, 1, 0);
        cyc("R3 reset d0 low", 0, A_RST, 0, 1, 0, 0, 0, 0, 1, 0);
        cyc("R3 reset miss", 0, A_ATTN + 32'h10, 1, 1, 1, 0, 0, 0, 1, 0);
        // R5 port strobe
        cyc("R5 port hit", 0, A_PORT, 0, 0, 0, 0, 0, 0, 1, 1);
        cyc("R5 port no strobe", 0, A_PORT, 1, 0, 0, 0, 0, 0, 1, 0);
        // R6 / R7 cycle-type lines
        cyc("R6 held", 0, A_OTHER, 1, 0, 0, 1, 1, 0, 0, 0);
        cyc("R7 hold only", 0, A_OTHER, 1, 0, 0, 1, 0, 0, 1, 0);
        cyc("R7 hlda only", 0, A_OTHER, 1, 0, 0, 0, 1, 0, 1, 1);
        // R8 snoop on coprocessor write into cacheable range
        cyc("R8 idle", 0, A_CACHE, 1, 1, 0, 1, 1, 1, 0, 0);
        cyc("R8 write", 0, A_CACHE, 0, 1, 0, 1, 1, 1, 0, 0);
        cyc("R8 end", 0, A_CACHE, 1, 1, 0, 1, 1, 1, 0, 0);
        // R9 read, outside range, hlda low
        cyc("R9 read", 0, A_CACHE, 0, 0, 0, 1, 1, 1, 0, 0);
        cyc("R9 gap", 0, A_CACHE, 1, 0, 0, 1, 1, 1, 0, 0);
        cyc("R9 outside", 0, A_OTHER, 0, 1, 0, 1, 1, 1, 0, 0);
        cyc("R9 gap2", 0, A_OTHER, 1, 1, 0, 0, 0, 1, 1, 0);
        cyc("R9 no hlda", 0, A_CACHE, 0, 1, 0, 1, 0, 1, 1, 0);
        cyc("R9 gap3", 0, A_CACHE, 1, 1, 0, 1, 1, 0, 0, 0);
        // R10 caching disabled
        cyc("R10 disabled", 0, A_CACHE, 0, 1, 0, 1, 1, 0, 0, 0);
        cyc("R10 gap", 0, A_CACHE, 1, 1, 0, 1, 1, 1, 0, 0);
        // R11 long strobe gives one pulse
        cyc("R11 long a", 0, A_CACHE, 0, 1, 0, 1, 1, 1, 0, 0);
        cyc("R11 long b", 0, A_CACHE, 0, 1, 0, 1, 1, 1, 0, 0);
        cyc("R11 long c", 0, A_CACHE, 0, 1, 0, 1, 1, 1, 0, 0);
        cyc("R11 end", 0, A_CACHE, 1, 1, 0, 0, 0, 1, 1, 0);
        // R4 reset mid-run
        cyc("R4 mid reset", 1, A_OTHER, 1, 0, 0, 0, 0, 0, 1, 0);
        cyc("R4 mid reset 2", 1, A_ATTN, 0, 1, 1, 0, 0, 0, 1, 0);
        cyc("R3 after reset", 0, A_OTHER, 1, 0, 0, 0, 0, 0, 1, 0);
        cyc("R1 final", 0, A_ATTN, 0, 1, 1, 0, 0, 0, 1, 0);
        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule